// File: doc/BRIEF.md
# Registered Command/Address Buffer with Parity Check

This block sits on the command path between a memory controller and a rank group of DDR3-style memory devices. On every rising clock edge it captures the chip selects, the command/address group (row/column address, bank address and the three command strobes), the clock-enable lines and the termination-enable lines. It re-drives the command/address group to two identical output copies. The command/address group passes through only on a cycle where exactly one active chip select is low. Clock-enable and termination-enable lines are registered and passed through on every cycle, whatever the chip selects do.

A static strap input sets the chip-select arrangement. With the strap high, the block runs in dual mode: two chip-select inputs are active, and each one drives a pair of outputs. With the strap low, it runs in quad mode: four inputs map one-to-one onto four outputs. On every forwarded cycle the block checks even parity over the command/address group and the parity input, and reports a failure on a registered active-low error line. The block also detects the chip-select pattern that marks a control-word write and reports it with a one-cycle strobe. In that case nothing is forwarded.

A small state machine records the class of the most recent captured cycle. The states are ST_RST (held in reset), ST_IDLE (no command), ST_FWD (command forwarded) and ST_CTL (control-word write). On each clock edge out of reset, the machine moves from any state to the state that matches the chip-select pattern just decoded. The outputs follow from that same decode. The transitions are reset-to-any, any-to-idle, any-to-forward and any-to-control, and reset forces ST_RST.

Top module: `cabuf_top`

## Requirements
- R1: While rst_n is low, the outputs are forced as follows: addresses and bank at 0, command strobes at all ones, all chip-select outputs at 1, clock-enable and termination outputs at 0, err_n_out at 1 and ctl_wr_out at 0.
- R2: On a forwarded cycle, the address, bank and command captured at a rising edge appear on both output copies right after that edge, one cycle of latency, and the two copies are identical.
- R3: A cycle is forwarded only when exactly one active chip select is low. On any other cycle, both command/address copies keep their previous values and all four chip-select outputs are 1.
- R4: cke_out and odt_out take the values of cke_in and odt_in captured at each edge, on every cycle, whatever the chip-select state.
- R5: Dual mode (dual_strap=1): only cs_n_in[1:0] are active and cs_n_in[3:2] are ignored. On a forwarded cycle, cs_n_out[0] and cs_n_out[2] carry cs_n_in[0], and cs_n_out[1] and cs_n_out[3] carry cs_n_in[1].
- R6: Quad mode (dual_strap=0): all four chip selects are active, and on a forwarded cycle cs_n_out[i] carries cs_n_in[i].
- R7: On a forwarded cycle where the number of ones across addr_in, bank_in, cmd_n_in and par_in is odd, err_n_out is 0 for exactly the one cycle after that edge. With even parity it stays 1. Chip selects, clock-enable and termination lines are not part of the count.
- R8: On a cycle that is not forwarded, parity is not evaluated and err_n_out is 1 after that edge.
- R9: A control-word write is decoded when cs_n_in[1:0] are both low and, in quad mode, cs_n_in[3:2] are both high. ctl_wr_out is then 1 for the one cycle after that edge, and nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_strap | input | 1 | 1 = dual chip-select mode, 0 = quad mode |
| cs_n_in | input | 4 | Chip selects, active low |
| addr_in | input | 16 | Row/column address |
| bank_in | input | 3 | Bank address |
| cmd_n_in | input | 3 | Command strobes {ras, cas, we}, active low |
| par_in | input | 1 | Even-parity bit over the command/address group |
| cke_in | input | 2 | Clock-enable lines, ungated |
| odt_in | input | 2 | Termination-enable lines, ungated |
| addr_a_out | output | 16 | Address, copy A |
| bank_a_out | output | 3 | Bank, copy A |
| cmd_n_a_out | output | 3 | Command strobes, copy A |
| addr_b_out | output | 16 | Address, copy B |
| bank_b_out | output | 3 | Bank, copy B |
| cmd_n_b_out | output | 3 | Command strobes, copy B |
| cs_n_out | output | 4 | Chip-select outputs, active low |
| cke_out | output | 2 | Registered clock-enable lines |
| odt_out | output | 2 | Registered termination-enable lines |
| err_n_out | output | 1 | Parity error, active low, one cycle per error |
| ctl_wr_out | output | 1 | Control-word write strobe |

## Verification
The hardest cases to reach are those where the chip-select decode and the parity check disagree about a cycle. One is an odd-parity beat on a cycle that carries no command, right after a forwarded beat that itself had a parity error. The error line must then show a single low cycle and the address outputs must not move. Another is a dual-mode beat where the ignored upper chip selects are low. Directed sequences place these beats back to back in both strap settings, with a reset between the modes. Biased random traffic then mixes single selects, control-word patterns, no-select and arbitrary patterns with about one parity flip in four beats. The behavioural model is compared on every clock.

// File: rtl/cabuf_pkg.sv
package cabuf_pkg;

    // Class of the most recently captured input cycle
    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_IDLE = 2'd1,
        ST_FWD  = 2'd2,
        ST_CTL  = 2'd3
    } cyc_st_e;

endpackage

// File: rtl/cabuf_cs_decode.sv
module cabuf_cs_decode
    import cabuf_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dual_strap,
    input  logic [NCS-1:0] cs_n,
    output cyc_st_e        kind,
    output logic [NCS-1:0] fan_n
);

    localparam int HALF  = NCS / 2;
    localparam int CNT_W = $clog2(NCS + 1);

    logic [CNT_W-1:0] low_cnt;
    logic             ctl_pat;

    // Count the asserted chip selects among the ones the strap makes active
    always_comb begin
        low_cnt = '0;
        for (int i = 0; i < NCS; i++) begin
            if (!cs_n[i] && (!dual_strap || i < HALF)) begin
                low_cnt = low_cnt + 1'b1;
            end
        end
    end

    // Control word: the two lowest selects low together, and no others
    assign ctl_pat = !cs_n[0] && !cs_n[1] && (low_cnt == CNT_W'(2));

    always_comb begin
        if (low_cnt == CNT_W'(1)) begin
            kind = ST_FWD;
        end else if (ctl_pat) begin
            kind = ST_CTL;
        end else begin
            kind = ST_IDLE;
        end
    end

    // Output fan-out: pairs in dual mode, one-to-one in quad mode
    for (genvar g = 0; g < NCS; g++) begin : g_fan
        assign fan_n[g] = dual_strap ? cs_n[g % HALF] : cs_n[g];
    end

    // R5 / R6: a forwarded cycle drives one select in quad mode, a pair in dual
    a_r5_r6_fan_count: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_FWD) |-> ($countones(~fan_n) == (dual_strap ? 2 : 1)));

    // R9: a control-word decode never coincides with a single-select count
    a_r9_ctl_two_low: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_CTL) |-> ($countones(~cs_n[1:0]) == 2));

endmodule

// File: rtl/cabuf_parity.sv
module cabuf_parity #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int CMD_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [CMD_W-1:0]  cmd_n,
    input  logic              par,
    output logic              odd
);

    localparam int TOT_W = ADDR_W + BANK_W + CMD_W + 1;

    logic [TOT_W-1:0] word;

    assign word = {addr, bank, cmd_n, par};

    // Even parity expected: an odd total of ones is an error
    assign odd = ^word;

endmodule

// File: rtl/cabuf_top.sv
module cabuf_top
    import cabuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int CMD_W  = 3,
    parameter int CKE_W  = 2,
    parameter int NCS    = 4,
    parameter int NCOPY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_strap,
    input  logic [NCS-1:0]    cs_n_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [CMD_W-1:0]  cmd_n_in,
    input  logic              par_in,
    input  logic [CKE_W-1:0]  cke_in,
    input  logic [CKE_W-1:0]  odt_in,
    output logic [ADDR_W-1:0] addr_a_out,
    output logic [BANK_W-1:0] bank_a_out,
    output logic [CMD_W-1:0]  cmd_n_a_out,
    output logic [ADDR_W-1:0] addr_b_out,
    output logic [BANK_W-1:0] bank_b_out,
    output logic [CMD_W-1:0]  cmd_n_b_out,
    output logic [NCS-1:0]    cs_n_out,
    output logic [CKE_W-1:0]  cke_out,
    output logic [CKE_W-1:0]  odt_out,
    output logic              err_n_out,
    output logic              ctl_wr_out
);

    localparam int CA_W = ADDR_W + BANK_W + CMD_W;
    localparam logic [CA_W-1:0] CA_RST = {{(ADDR_W + BANK_W){1'b0}}, {CMD_W{1'b1}}};

    cyc_st_e          kind;
    cyc_st_e          st_q;
    logic [NCS-1:0]   fan_n;
    logic             par_odd;
    logic [CA_W-1:0]  ca_in;
    logic [NCS-1:0]   cs_q;
    logic [CKE_W-1:0] cke_q;
    logic [CKE_W-1:0] odt_q;
    logic             err_n_q;
    logic             ctl_q;

    assign ca_in = {addr_in, bank_in, cmd_n_in};

    cabuf_cs_decode #(
        .NCS (NCS)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_strap (dual_strap),
        .cs_n       (cs_n_in),
        .kind       (kind),
        .fan_n      (fan_n)
    );

    cabuf_parity #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .CMD_W  (CMD_W)
    ) u_par (
        .addr  (addr_in),
        .bank  (bank_in),
        .cmd_n (cmd_n_in),
        .par   (par_in),
        .odd   (par_odd)
    );

    // State register: class of the last captured cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= kind;
        end
    end

    // Output register process, driven by the current decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= '1;
            cke_q   <= '0;
            odt_q   <= '0;
            err_n_q <= 1'b1;
            ctl_q   <= 1'b0;
        end else begin
            cke_q <= cke_in;
            odt_q <= odt_in;
            unique case (kind)
                ST_FWD: begin
                    cs_q    <= fan_n;
                    err_n_q <= ~par_odd;
                    ctl_q   <= 1'b0;
                end
                ST_CTL: begin
                    cs_q    <= '1;
                    err_n_q <= 1'b1;
                    ctl_q   <= 1'b1;
                end
                default: begin
                    cs_q    <= '1;
                    err_n_q <= 1'b1;
                    ctl_q   <= 1'b0;
                end
            endcase
        end
    end

    // Command/address output copies, one register set per copy
    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        logic [CA_W-1:0] ca_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ca_r <= CA_RST;
            end else if (kind == ST_FWD) begin
                ca_r <= ca_in;
            end
        end
    end

    assign {addr_a_out, bank_a_out, cmd_n_a_out} = g_copy[0].ca_r;
    assign {addr_b_out, bank_b_out, cmd_n_b_out} = g_copy[NCOPY-1].ca_r;
    assign cs_n_out   = cs_q;
    assign cke_out    = cke_q;
    assign odt_out    = odt_q;
    assign err_n_out  = err_n_q;
    assign ctl_wr_out = ctl_q;

    // R3: without a forwarded command, every select output idles high next cycle
    a_r3_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ST_FWD) |=> (cs_n_out == '1));

    // R3: without a forwarded command, the command/address copy holds
    a_r3_ca_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ST_FWD) |=> ($stable(addr_a_out) && $stable(bank_a_out) && $stable(cmd_n_a_out)));

    // R2: the two copies agree
    a_r2_copy_match: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_a_out == addr_b_out) && (bank_a_out == bank_b_out) && (cmd_n_a_out == cmd_n_b_out));

    // R7 / R8: an error flag only follows a forwarded cycle
    a_r7_err_after_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n_out |-> (st_q == ST_FWD));

    // R9: the control strobe never comes with an active select output
    a_r9_ctl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_out |-> ((cs_n_out == '1) && (st_q == ST_CTL)));

    // R4: the ungated lines follow their inputs with one cycle of latency
    a_r4_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RST) |-> ((cke_out == $past(cke_in)) && (odt_out == $past(odt_in))));

endmodule

// File: tb/cabuf_top_tb_top.sv
module cabuf_top_tb_top;

    localparam int AW = 16;
    localparam int BW = 3;
    localparam int CW = 3;
    localparam int KW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dual_strap;
    logic [3:0]    cs_n_in;
    logic [AW-1:0] addr_in;
    logic [BW-1:0] bank_in;
    logic [CW-1:0] cmd_n_in;
    logic          par_in;
    logic [KW-1:0] cke_in;
    logic [KW-1:0] odt_in;
    logic [AW-1:0] addr_a_out, addr_b_out;
    logic [BW-1:0] bank_a_out, bank_b_out;
    logic [CW-1:0] cmd_n_a_out, cmd_n_b_out;
    logic [3:0]    cs_n_out;
    logic [KW-1:0] cke_out, odt_out;
    logic          err_n_out, ctl_wr_out;

    always #10 clk = ~clk;

    cabuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .dual_strap(dual_strap), .cs_n_in(cs_n_in),
        .addr_in(addr_in), .bank_in(bank_in), .cmd_n_in(cmd_n_in), .par_in(par_in),
        .cke_in(cke_in), .odt_in(odt_in),
        .addr_a_out(addr_a_out), .bank_a_out(bank_a_out), .cmd_n_a_out(cmd_n_a_out),
        .addr_b_out(addr_b_out), .bank_b_out(bank_b_out), .cmd_n_b_out(cmd_n_b_out),
        .cs_n_out(cs_n_out), .cke_out(cke_out), .odt_out(odt_out),
        .err_n_out(err_n_out), .ctl_wr_out(ctl_wr_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [AW-1:0] e_addr;
    logic [BW-1:0] e_bank;
    logic [CW-1:0] e_cmd;
    logic [3:0]    e_cs;
    logic [KW-1:0] e_cke, e_odt;
    logic          e_err, e_ctl;
    string t_ca, t_cs, t_err, t_ctl, t_k;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(t_ca, "addr_a", 32'(addr_a_out), 32'(e_addr));
        chk(t_ca, "addr_b", 32'(addr_b_out), 32'(e_addr));
        chk(t_ca, "bank_a", 32'(bank_a_out), 32'(e_bank));
        chk(t_ca, "bank_b", 32'(bank_b_out), 32'(e_bank));
        chk(t_ca, "cmd_a",  32'(cmd_n_a_out), 32'(e_cmd));
        chk(t_ca, "cmd_b",  32'(cmd_n_b_out), 32'(e_cmd));
        chk(t_cs, "cs_out", 32'(cs_n_out), 32'(e_cs));
        chk(t_k,  "cke",    32'(cke_out), 32'(e_cke));
        chk(t_k,  "odt",    32'(odt_out), 32'(e_odt));
        chk(t_err, "err_n", 32'(err_n_out), 32'(e_err));
        chk(t_ctl, "ctl_wr", 32'(ctl_wr_out), 32'(e_ctl));
    endtask

    // Apply reset with the given strap and check the forced values (R1)
    task automatic do_reset(input logic strap);
        rst_n      = 1'b0;
        dual_strap = strap;
        cs_n_in    = 4'hF;
        addr_in    = 16'h5A5A;
        bank_in    = 3'd6;
        cmd_n_in   = 3'b010;
        par_in     = 1'b1;
        cke_in     = 2'b11;
        odt_in     = 2'b11;
        repeat (3) @(negedge clk);
        e_addr = '0; e_bank = '0; e_cmd = '1; e_cs = 4'hF;
        e_cke = '0; e_odt = '0; e_err = 1'b1; e_ctl = 1'b0;
        t_ca = "R1"; t_cs = "R1"; t_err = "R1"; t_ctl = "R1"; t_k = "R1";
        compare_all();
        rst_n = 1'b1;
    endtask

    // Drive one beat, advance the model, compare after the capturing edge
    task automatic step(input logic [3:0] cs, input logic [AW-1:0] a, input logic [BW-1:0] b,
                        input logic [CW-1:0] c, input logic flip, input logic [KW-1:0] k,
                        input logic [KW-1:0] o);
        int  lows = 0;
        int  act  = dual_strap ? 2 : 4;
        bit  fwd, ctl;
        logic p;
        for (int i = 0; i < act; i++) if (!cs[i]) lows++;
        fwd = (lows == 1);
        ctl = dual_strap ? (cs[1:0] == 2'b00) : (cs == 4'b1100);
        p = 1'($countones({a, b, c}) % 2) ^ flip;
        cs_n_in = cs; addr_in = a; bank_in = b; cmd_n_in = c; par_in = p;
        cke_in = k; odt_in = o;
        if (fwd) begin
            e_addr = a; e_bank = b; e_cmd = c;
            e_cs   = dual_strap ? {cs[1], cs[0], cs[1], cs[0]} : cs;
            e_err  = ($countones({a, b, c, p}) % 2 == 1) ? 1'b0 : 1'b1;
        end else begin
            e_cs  = 4'hF;
            e_err = 1'b1;
        end
        e_cke = k; e_odt = o;
        e_ctl = ctl && !fwd;
        t_ca  = fwd ? "R2" : "R3";
        t_cs  = fwd ? (dual_strap ? "R5" : "R6") : "R3";
        t_err = fwd ? "R7" : "R8";
        t_ctl = "R9";
        t_k   = "R4";
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_beats(input int n);
        for (int j = 0; j < n; j++) begin
            logic [3:0] cs;
            int sel = $urandom % 4;
            int act = dual_strap ? 2 : 4;
            if (sel == 0)      cs = ~(4'b1 << ($urandom % act));
            else if (sel == 1) cs = 4'hF;
            else if (sel == 2) cs = 4'b1100;
            else               cs = 4'($urandom);
            step(cs, 16'($urandom), 3'($urandom), 3'($urandom), ($urandom % 4) == 0,
                 2'($urandom), 2'($urandom));
        end
    endtask

    initial begin
        // Dual mode
        do_reset(1'b1);
        step(4'b1110, 16'h1234, 3'd5, 3'b011, 1'b0, 2'b01, 2'b10); // R2 R5 cs0, good parity
        step(4'b1101, 16'hABCD, 3'd2, 3'b101, 1'b1, 2'b11, 2'b00); // R7 cs1, bad parity
        step(4'b1111, 16'hFFFF, 3'd7, 3'b000, 1'b1, 2'b10, 2'b01); // R8 R3 idle, bad parity
        step(4'b1100, 16'h0F0F, 3'd1, 3'b110, 1'b1, 2'b00, 2'b11); // R9 control word
        step(4'b0010, 16'h8001, 3'd4, 3'b001, 1'b0, 2'b01, 2'b01); // R5 upper lows ignored
        step(4'b0011, 16'h7777, 3'd3, 3'b100, 1'b1, 2'b10, 2'b10); // R5 only upper low -> idle
        step(4'b1110, 16'h0001, 3'd0, 3'b111, 1'b1, 2'b11, 2'b11); // R7 back-to-back errors
        step(4'b1101, 16'h0002, 3'd0, 3'b111, 1'b1, 2'b00, 2'b00); // R7
        step(4'b1111, 16'h0003, 3'd0, 3'b111, 1'b0, 2'b01, 2'b10); // R7 single-cycle pulse ends
        rand_beats(300);
        // Quad mode
        do_reset(1'b0);
        step(4'b1110, 16'h1111, 3'd1, 3'b011, 1'b0, 2'b01, 2'b00); // R6
        step(4'b1101, 16'h2222, 3'd2, 3'b101, 1'b0, 2'b10, 2'b01); // R6
        step(4'b1011, 16'h3333, 3'd3, 3'b110, 1'b1, 2'b11, 2'b10); // R6 R7
        step(4'b0111, 16'h4444, 3'd4, 3'b111, 1'b0, 2'b00, 2'b11); // R6
        step(4'b1100, 16'h5555, 3'd5, 3'b000, 1'b1, 2'b01, 2'b01); // R9 quad control word
        step(4'b0011, 16'h6666, 3'd6, 3'b010, 1'b1, 2'b10, 2'b10); // R3 R8 two selects
        step(4'b1010, 16'h9999, 3'd7, 3'b001, 1'b0, 2'b11, 2'b00); // R3 two selects
        step(4'b0000, 16'hAAAA, 3'd0, 3'b100, 1'b1, 2'b00, 2'b01); // R3 all selects
        rand_beats(300);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule